// File: doc/BRIEF.md
# Activation-Count Victim Refresh Tracker

This block watches the activate commands of one DRAM bank and keeps a saturating activation counter for every row in a small on-chip table. A repeatedly opened row disturbs the rows on either side of it. When the activations on the two sides of a row add up to a programmable limit, that row is treated as a victim. Its index is then placed in a small request queue so that a targeted refresh can be issued.

The counters cover one bounded time window. The window length is given as a number of periodic refresh ticks; a typical setting spans the 64 ms retention period. When a window ends, every counter is cleared. The activate limit is an input, and a typical value lies between about 20,000 and 60,000. The bench uses small values. Queued victims leave through a valid/ready port.

Evaluation is run by a four-state controller:
- **S_IDLE** accepts an activate for evaluation and moves to S_EVAL.
- **S_EVAL** reads the counters around the activated row. It moves to S_PUSH_LO if the lower neighbour is flagged, otherwise to S_PUSH_HI if the upper neighbour is flagged, otherwise back to S_IDLE.
- **S_PUSH_LO** queues the lower victim, then moves to S_PUSH_HI if the upper victim was also flagged, otherwise to S_IDLE.
- **S_PUSH_HI** queues the upper victim and returns to S_IDLE.

Top module: `trr_tracker`

## Requirements
- R1: Every cycle with `act_valid` high adds one to the counter of `act_row`; a counter stops at its all-ones value.
- R2: When the activated row R has a count of at least `mac_limit`, both rows R-1 and R+1 are queued, with R-1 entering the queue first.
- R3: A victim row V is queued when count(V-1) + count(V+1) is at least `mac_limit`, even if neither count alone reaches it. A row outside the array counts as zero.
- R4: No victim below row 0 or above row ROWS-1 is ever queued; such a victim is dropped, not wrapped to the other end of the array.
- R5: Queueing victim V clears the counters of rows V-1 and V+1, so the same activations do not raise the request again.
- R6: `ref_tick` pulses are counted. The pulse that completes `win_ticks` ticks clears every counter; earlier pulses clear nothing.
- R7: If an activate coincides with the window-ending tick, the activated row's counter becomes 1.
- R8: The limit is taken from `mac_limit` at evaluation time, and the comparison is greater-or-equal.
- R9: Requests leave in the order they were queued on `req_valid`/`req_ready`. While `req_valid` is high and `req_ready` is low, `req_row` stays unchanged.
- R10: The queue holds FIFO_DEPTH entries. A request that arrives while the queue is full is dropped and sets `overflow`, which stays high until reset.
- R11: After reset, `req_valid` and `overflow` are low and all counters are zero.
- R12: An activate is evaluated only when it arrives in S_IDLE, and its lower victim appears on `req_valid` after the third rising edge counted from the activate's edge. Activates must therefore be at least four cycles apart for each one to be evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | Activate strobe |
| act_row | input | $clog2(ROWS) | Row opened by the activate |
| ref_tick | input | 1 | Periodic refresh tick, one cycle wide |
| mac_limit | input | CNT_W | Activation limit per window |
| win_ticks | input | WIN_W | Window length in refresh ticks |
| req_valid | output | 1 | Victim request available |
| req_row | output | $clog2(ROWS) | Victim row to refresh |
| req_ready | input | 1 | Consumer accepts the request |
| overflow | output | 1 | Sticky flag: a request was dropped |

## Verification
The bench drives several activation patterns, and each one separates a different failure:
- **Single hammered row:** shows whether both neighbours are queued in the right order, and whether the count is cleared once they are.
- **Unequal activations on two rows two apart:** catches a design that only compares individual counts against the limit.
- **Hammering row 0 and the last row:** exposes wrap-around of victim indices.
- **Partial windows, full windows, and an activate that lands on the window-ending tick:** separate a design that clears too early, too late, or lets the activate lose to the clear.
- **Filling the queue while the consumer stalls:** checks ordering, dropping and the sticky flag.
- **Activates just below and at a raised limit:** show that the limit is programmable and that the comparison is greater-or-equal.

// File: rtl/trr_pkg.sv
package trr_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_EVAL,
        S_PUSH_LO,
        S_PUSH_HI
    } trr_state_e;

endpackage

// File: rtl/trr_count_table.sv
module trr_count_table #(
    parameter int ROWS  = 16,
    parameter int CNT_W = 16,
    parameter int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_clr,
    input  logic             inc_en,
    input  logic [ROW_W-1:0] inc_row,
    input  logic             clr_a_en,
    input  logic [ROW_W-1:0] clr_a_row,
    input  logic             clr_b_en,
    input  logic [ROW_W-1:0] clr_b_row,
    input  logic [ROW_W-1:0] rd_row,
    output logic [CNT_W-1:0] rd_lo2,
    output logic [CNT_W-1:0] rd_mid,
    output logic [CNT_W-1:0] rd_hi2
);

    localparam logic [ROW_W-1:0] TWO     = ROW_W'(2);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q [ROWS];
    logic [CNT_W-1:0] cnt_d [ROWS];

    // Priority: a clear (window end or victim issue) zeroes the count, then a
    // same-cycle activate adds one on top of it.
    always_comb begin
        for (int i = 0; i < ROWS; i++) begin
            logic             hit_clr;
            logic [CNT_W-1:0] base;
            hit_clr = win_clr
                   || (clr_a_en && int'(clr_a_row) == i)
                   || (clr_b_en && int'(clr_b_row) == i);
            base = hit_clr ? '0 : cnt_q[i];
            if (inc_en && int'(inc_row) == i && base != CNT_MAX)
                base = base + 1'b1;
            cnt_d[i] = base;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ROWS; i++) begin
            if (!rst_n) cnt_q[i] <= '0;
            else        cnt_q[i] <= cnt_d[i];
        end
    end

    // Neighbours at distance two; rows outside the array read as zero.
    always_comb begin
        rd_mid = cnt_q[rd_row];
        rd_lo2 = (int'(rd_row) >= 2)       ? cnt_q[rd_row - TWO] : '0;
        rd_hi2 = (int'(rd_row) + 2 < ROWS) ? cnt_q[rd_row + TWO] : '0;
    end

    for (genvar g = 0; g < ROWS; g++) begin : g_row_chk
        AST_WIN_CLEARS_ROW: assert property (@(posedge clk) disable iff (!rst_n) win_clr |=> cnt_q[g] <= CNT_W'(1)); // R6
        AST_ACT_INCREMENTS: assert property (@(posedge clk) disable iff (!rst_n) (inc_en && int'(inc_row) == g && !win_clr && !clr_a_en && !clr_b_en && cnt_q[g] != CNT_MAX) |=> cnt_q[g] == $past(cnt_q[g]) + 1'b1); // R1
    end

endmodule

// File: rtl/trr_req_fifo.sv
module trr_req_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_ready,
    output logic         overflow
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [PTR_W:0]   count_q;
    logic             full, do_wr, do_rd;

    assign full      = count_q == (PTR_W+1)'(DEPTH);
    assign out_valid = count_q != '0;
    assign out_data  = mem_q[rp_q];
    assign do_wr     = push && !full;
    assign do_rd     = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q     <= '0;
            rp_q     <= '0;
            count_q  <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_wr) begin
                mem_q[wp_q] <= push_data;
                wp_q <= (int'(wp_q) == DEPTH-1) ? '0 : wp_q + 1'b1;
            end
            if (do_rd)
                rp_q <= (int'(rp_q) == DEPTH-1) ? '0 : rp_q + 1'b1;
            count_q <= count_q + (PTR_W+1)'(do_wr) - (PTR_W+1)'(do_rd);
            if (push && full)
                overflow <= 1'b1;
        end
    end

    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (push && full) |=> overflow); // R10
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overflow |=> overflow); // R10
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

endmodule

// File: rtl/trr_tracker.sv
module trr_tracker
    import trr_pkg::*;
#(
    parameter int ROWS       = 16,
    parameter int CNT_W      = 16,
    parameter int WIN_W      = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    act_valid,
    input  logic [$clog2(ROWS)-1:0] act_row,
    input  logic                    ref_tick,
    input  logic [CNT_W-1:0]        mac_limit,
    input  logic [WIN_W-1:0]        win_ticks,
    output logic                    req_valid,
    output logic [$clog2(ROWS)-1:0] req_row,
    input  logic                    req_ready,
    output logic                    overflow
);

    localparam int ROW_W = $clog2(ROWS);
    localparam logic [ROW_W-1:0] ONE = ROW_W'(1);
    localparam logic [ROW_W-1:0] TWO = ROW_W'(2);

    trr_state_e       state_q, state_d;
    logic [ROW_W-1:0] row_q;
    logic             flag_lo_q, flag_hi_q;
    logic [WIN_W-1:0] tick_q;
    logic [WIN_W:0]   tick_nx;
    logic             win_end;

    logic [CNT_W-1:0] c_lo2, c_mid, c_hi2;
    logic [CNT_W:0]   sum_lo, sum_hi;
    logic             has_lo, has_hi, hit_lo, hit_hi;

    logic             push;
    logic [ROW_W-1:0] push_row;
    logic             clr_a_en, clr_b_en;
    logic [ROW_W-1:0] clr_a_row, clr_b_row;

    // Window: the tick that completes win_ticks ticks ends the window.
    assign tick_nx = {1'b0, tick_q} + 1'b1;
    assign win_end = ref_tick && (tick_nx >= {1'b0, win_ticks});

    always_ff @(posedge clk) begin
        if (!rst_n)        tick_q <= '0;
        else if (win_end)  tick_q <= '0;
        else if (ref_tick) tick_q <= tick_nx[WIN_W-1:0];
    end

    // Threshold test on the counts around the latched row.
    assign has_lo = row_q != '0;
    assign has_hi = int'(row_q) != ROWS-1;
    assign sum_lo = {1'b0, c_lo2} + {1'b0, c_mid};
    assign sum_hi = {1'b0, c_mid} + {1'b0, c_hi2};
    assign hit_lo = has_lo && (sum_lo >= {1'b0, mac_limit});
    assign hit_hi = has_hi && (sum_hi >= {1'b0, mac_limit});

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Row and flag capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q     <= '0;
            flag_lo_q <= 1'b0;
            flag_hi_q <= 1'b0;
        end else begin
            if (state_q == S_IDLE && act_valid)
                row_q <= act_row;
            if (state_q == S_EVAL) begin
                flag_lo_q <= hit_lo;
                flag_hi_q <= hit_hi;
            end
        end
    end

    // Next state and outputs.
    always_comb begin
        state_d   = state_q;
        push      = 1'b0;
        push_row  = '0;
        clr_a_en  = 1'b0;
        clr_a_row = '0;
        clr_b_en  = 1'b0;
        clr_b_row = '0;
        unique case (state_q)
            S_IDLE: begin
                if (act_valid) state_d = S_EVAL;
            end
            S_EVAL: begin
                if (hit_lo)      state_d = S_PUSH_LO;
                else if (hit_hi) state_d = S_PUSH_HI;
                else             state_d = S_IDLE;
            end
            S_PUSH_LO: begin
                push      = 1'b1;
                push_row  = row_q - ONE;
                clr_a_en  = int'(row_q) >= 2;
                clr_a_row = row_q - TWO;
                clr_b_en  = 1'b1;
                clr_b_row = row_q;
                state_d   = flag_hi_q ? S_PUSH_HI : S_IDLE;
            end
            S_PUSH_HI: begin
                push      = 1'b1;
                push_row  = row_q + ONE;
                clr_a_en  = 1'b1;
                clr_a_row = row_q;
                clr_b_en  = int'(row_q) + 2 < ROWS;
                clr_b_row = row_q + TWO;
                state_d   = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    trr_count_table #(
        .ROWS (ROWS),
        .CNT_W(CNT_W),
        .ROW_W(ROW_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_clr  (win_end),
        .inc_en   (act_valid),
        .inc_row  (act_row),
        .clr_a_en (clr_a_en),
        .clr_a_row(clr_a_row),
        .clr_b_en (clr_b_en),
        .clr_b_row(clr_b_row),
        .rd_row   (row_q),
        .rd_lo2   (c_lo2),
        .rd_mid   (c_mid),
        .rd_hi2   (c_hi2)
    );

    trr_req_fifo #(
        .DEPTH(FIFO_DEPTH),
        .W    (ROW_W)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_data(push_row),
        .out_valid(req_valid),
        .out_data (req_row),
        .out_ready(req_ready),
        .overflow (overflow)
    );

    AST_HI_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (state_q == S_PUSH_HI) |=> (state_q == S_IDLE)); // R12
    AST_ACT_STARTS_EVAL: assert property (@(posedge clk) disable iff (!rst_n) (state_q == S_IDLE && act_valid) |=> (state_q == S_EVAL)); // R12
    AST_NO_LOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (state_q == S_EVAL && row_q == '0) |=> (state_q != S_PUSH_LO)); // R4
    AST_NO_HIGH_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (state_q == S_EVAL && int'(row_q) == ROWS-1) |=> (state_q != S_PUSH_HI)); // R4

endmodule

// File: tb/trr_tracker_bench.sv
`timescale 1ns/1ps
module trr_tracker_bench;

    localparam int ROWS  = 16;
    localparam int CNT_W = 16;
    localparam int WIN_W = 16;
    localparam int DEPTH = 4;
    localparam int RW    = $clog2(ROWS);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             act_valid;
    logic [RW-1:0]    act_row;
    logic             ref_tick;
    logic [CNT_W-1:0] mac_limit;
    logic [WIN_W-1:0] win_ticks;
    logic             req_valid;
    logic [RW-1:0]    req_row;
    logic             req_ready;
    logic             overflow;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    trr_tracker #(
        .ROWS(ROWS), .CNT_W(CNT_W), .WIN_W(WIN_W), .FIFO_DEPTH(DEPTH)
    ) u_trr_tracker (
        .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_row(act_row),
        .ref_tick(ref_tick), .mac_limit(mac_limit), .win_ticks(win_ticks),
        .req_valid(req_valid), .req_row(req_row), .req_ready(req_ready),
        .overflow(overflow)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic do_reset(input int mac, input int win);
        @(negedge clk);
        rst_n = 1'b0; act_valid = 1'b0; act_row = '0; ref_tick = 1'b0;
        req_ready = 1'b0; mac_limit = CNT_W'(mac); win_ticks = WIN_W'(win);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic act(input int row);
        act_valid = 1'b1; act_row = RW'(row);
        @(negedge clk);
        act_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            ref_tick = 1'b1;
            @(negedge clk);
            ref_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic pop_expect(input string req, input int row);
        check({req, " valid"}, int'(req_valid), 1);
        check({req, " row"}, int'(req_row), row);
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
    endtask

    task automatic expect_empty(input string req);
        check({req, " empty"}, int'(req_valid), 0);
    endtask

    task automatic t_reset;
        do_reset(3, 4);
        check("R11 valid", int'(req_valid), 0);
        check("R11 overflow", int'(overflow), 0);
        act(5); act(5);
        expect_empty("R11 counters start at zero");
    endtask

    task automatic t_single_and_timing;
        do_reset(3, 4);
        act(5); act(5);
        expect_empty("R1 below limit");
        act_valid = 1'b1; act_row = RW'(5);
        @(negedge clk);
        act_valid = 1'b0;
        @(negedge clk);
        check("R12 not yet queued", int'(req_valid), 0);
        @(negedge clk);
        check("R12 queued on third edge", int'(req_valid), 1);
        repeat (2) @(negedge clk);
        pop_expect("R2 lower first", 4);
        pop_expect("R2 upper", 6);
        expect_empty("R2 only two");
        act(5); act(5);
        expect_empty("R5 counters cleared after issue");
    endtask

    task automatic t_pair;
        do_reset(3, 4);
        act(8); act(8);
        expect_empty("R3 no early flag");
        act(10);
        pop_expect("R3 combined neighbours", 9);
        expect_empty("R3 single request");
    endtask

    task automatic t_edges;
        do_reset(3, 4);
        act(0); act(0); act(0);
        pop_expect("R4 row0 upper victim", 1);
        expect_empty("R4 no wrap at row 0");
        act(ROWS-1); act(ROWS-1); act(ROWS-1);
        pop_expect("R4 last row lower victim", ROWS-2);
        expect_empty("R4 no wrap at last row");
    endtask

    task automatic t_window;
        do_reset(3, 4);
        act(3); act(3);
        tick(3);
        act(3);
        pop_expect("R6 partial window keeps counts", 2);
        pop_expect("R6 partial window upper", 4);
        do_reset(3, 4);
        act(3); act(3);
        tick(4);
        act(3);
        expect_empty("R6 full window clears");
        act(3); act(3);
        pop_expect("R6 recount lower", 2);
        pop_expect("R6 recount upper", 4);
    endtask

    task automatic t_collision;
        do_reset(3, 2);
        act(7); act(7);
        tick(1);
        ref_tick = 1'b1; act_valid = 1'b1; act_row = RW'(7);
        @(negedge clk);
        ref_tick = 1'b0; act_valid = 1'b0;
        repeat (4) @(negedge clk);
        expect_empty("R7 restart at one");
        act(7);
        expect_empty("R7 count two");
        act(7);
        pop_expect("R7 third activate lower", 6);
        pop_expect("R7 third activate upper", 8);
    endtask

    task automatic t_mac;
        do_reset(5, 4);
        act(11); act(11); act(11); act(11);
        expect_empty("R8 four below five");
        act(11);
        pop_expect("R8 equal reaches limit", 10);
        pop_expect("R8 upper", 12);
    endtask

    task automatic t_overflow;
        do_reset(3, 4);
        act(2); act(2); act(2);
        act(9); act(9); act(9);
        check("R10 no overflow when full", int'(overflow), 0);
        check("R9 head held while stalled", int'(req_row), 1);
        act(13); act(13); act(13);
        check("R10 overflow set", int'(overflow), 1);
        pop_expect("R9 order 0", 1);
        pop_expect("R9 order 1", 3);
        pop_expect("R9 order 2", 8);
        pop_expect("R9 order 3", 10);
        expect_empty("R10 dropped requests");
        check("R10 overflow sticky", int'(overflow), 1);
    endtask

    initial begin
        t_reset();
        t_single_and_timing();
        t_pair();
        t_edges();
        t_window();
        t_collision();
        t_mac();
        t_overflow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule